// File: doc/BRIEF.md
# Byte Shuffle Unit with Zeroing

This block rearranges the bytes of a 128-bit data operand. A control operand of the same width supplies one control byte for each output byte. Each control byte either names the source byte to copy into its output lane or forces that lane to zero. Every output lane decodes its own control byte and has its own source index. Any output lane can therefore take any source byte, and several lanes can take the same one.

The unit sits in a vector datapath. It receives a data vector, a control vector and a valid strobe together. With the default build, the shuffled vector and its valid flag come out of a single register stage one clock later. A parameter removes the stage and gives a purely combinational path. All lanes select from one unmodified copy of the incoming data. The result is therefore correct when the data and control operands are the same value.

Top module: `byte_shuffle_unit`

## Requirements
- R1: Output byte k (bits 8k+7..8k) is set only by control byte k (bits 8k+7..8k) and by the data vector. Changing any other control byte leaves output byte k unchanged.
- R2: When bit 7 of control byte k is 1, output byte k is 0x00.
- R3: When bit 7 of control byte k is 0, output byte k equals data byte n, where n is bits 3..0 of control byte k (0 to 15).
- R4: Bits 6..4 of each control byte have no effect on the result.
- R5: When the data and control inputs carry the same value, every lane selects from the original data bytes. Each output byte equals the result computed from that unmodified value.
- R6: In the registered build, out_valid is 1 exactly one clock after a cycle with in_valid 1, and 0 one clock after a cycle with in_valid 0.
- R7: While rst_n is 0 at a rising clock edge, out_data and out_valid are both cleared to 0 at that edge (synchronous, active low).
- R8: In the registered build, out_data loads only in cycles with in_valid 1. It holds its previous value in cycles with in_valid 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Data and control vectors are valid this cycle |
| in_data | input | 128 | Source bytes, byte k at bits 8k+7..8k |
| in_ctrl | input | 128 | One control byte per output lane: bit 7 forces zero, bits 3..0 give the source index |
| out_valid | output | 1 | Shuffled result is valid |
| out_data | output | 128 | Shuffled vector |

## Verification
The bench builds the unit with its default parameters: sixteen 8-bit lanes and the register stage enabled. This covers the one-clock valid timing, reset clearing and data hold as well as the lane selection. The full 4-bit index and the zero-force bit are exercised in every lane. Directed vectors cover the following cases:
- all-zero and all-zeroing masks
- identity and reversed orders
- a broadcast of one byte
- control bytes with the ignored bits set
- data and control driven with the same value

Random vectors then cover mixed zeroing and repeated sources.

// File: rtl/bshuf_pkg.sv
package bshuf_pkg;

  localparam int unsigned DEF_LANES  = 16;
  localparam int unsigned DEF_BYTE_W = 8;

  typedef enum logic {
    LANE_COPY = 1'b0,
    LANE_ZERO = 1'b1
  } lane_mode_e;

endpackage

// File: rtl/bshuf_ctrl_decode.sv
module bshuf_ctrl_decode
  import bshuf_pkg::*;
#(
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned BYTE_W = DEF_BYTE_W,
  localparam int unsigned IDX_W = $clog2(LANES)
) (
  input  logic [BYTE_W-1:0] ctrl_byte,
  output lane_mode_e        mode,
  output logic [IDX_W-1:0]  src_idx
);

  // Top bit of the control byte forces the lane to zero.
  function automatic lane_mode_e mode_of(input logic [BYTE_W-1:0] c);
    return c[BYTE_W-1] ? LANE_ZERO : LANE_COPY;
  endfunction

  // Low bits name the source byte; the bits in between are don't-care.
  function automatic logic [IDX_W-1:0] index_of(input logic [BYTE_W-1:0] c);
    return c[IDX_W-1:0];
  endfunction

  logic [BYTE_W-1:0] unused_mid;

  always_comb begin
    mode       = mode_of(ctrl_byte);
    src_idx    = index_of(ctrl_byte);
    unused_mid = ctrl_byte;
  end

  logic unused_ok;
  assign unused_ok = ^unused_mid[BYTE_W-2:IDX_W];

endmodule

// File: rtl/bshuf_lane.sv
module bshuf_lane
  import bshuf_pkg::*;
#(
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned BYTE_W = DEF_BYTE_W,
  localparam int unsigned IDX_W = $clog2(LANES),
  localparam int unsigned VEC_W = LANES * BYTE_W
) (
  input  logic [VEC_W-1:0]  src_vec,
  input  lane_mode_e        mode,
  input  logic [IDX_W-1:0]  src_idx,
  output logic [BYTE_W-1:0] lane_out,
  output logic              lane_zero
);

  logic [BYTE_W-1:0] picked;

  // One-hot compare per source position, OR-reduced.
  always_comb begin
    picked = '0;
    for (int j = 0; j < LANES; j++) begin
      if (src_idx == IDX_W'(j)) begin
        picked = picked | src_vec[j*BYTE_W +: BYTE_W];
      end
    end
  end

  assign lane_zero = (mode == LANE_ZERO);
  assign lane_out  = lane_zero ? '0 : picked;

endmodule

// File: rtl/bshuf_xbar.sv
module bshuf_xbar
  import bshuf_pkg::*;
#(
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned BYTE_W = DEF_BYTE_W,
  localparam int unsigned IDX_W = $clog2(LANES),
  localparam int unsigned VEC_W = LANES * BYTE_W
) (
  input  logic [VEC_W-1:0] src_vec,
  input  logic [VEC_W-1:0] ctrl_vec,
  output logic [VEC_W-1:0] shuf_vec,
  output logic [LANES-1:0] zero_mask
);

  // Every lane reads the same unmodified source snapshot.
  logic [VEC_W-1:0] src_snap;
  assign src_snap = src_vec;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    lane_mode_e       mode_k;
    logic [IDX_W-1:0] idx_k;

    bshuf_ctrl_decode #(
      .LANES (LANES),
      .BYTE_W(BYTE_W)
    ) dec_i (
      .ctrl_byte(ctrl_vec[k*BYTE_W +: BYTE_W]),
      .mode     (mode_k),
      .src_idx  (idx_k)
    );

    bshuf_lane #(
      .LANES (LANES),
      .BYTE_W(BYTE_W)
    ) lane_i (
      .src_vec  (src_snap),
      .mode     (mode_k),
      .src_idx  (idx_k),
      .lane_out (shuf_vec[k*BYTE_W +: BYTE_W]),
      .lane_zero(zero_mask[k])
    );
  end

endmodule

// File: rtl/bshuf_stage.sv
module bshuf_stage #(
  parameter int unsigned WIDTH      = 128,
  parameter bit          REGISTERED = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             d_valid,
  input  logic [WIDTH-1:0] d_data,
  output logic             q_valid,
  output logic [WIDTH-1:0] q_data
);

  if (REGISTERED) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q_valid <= 1'b0;
        q_data  <= '0;
      end else begin
        q_valid <= d_valid;
        if (d_valid) begin
          q_data <= d_data;
        end
      end
    end
  end else begin : g_comb
    assign q_valid = d_valid;
    assign q_data  = d_data;
  end

endmodule

// File: rtl/byte_shuffle_unit.sv
module byte_shuffle_unit
  import bshuf_pkg::*;
#(
  parameter int unsigned LANES      = DEF_LANES,
  parameter int unsigned BYTE_W     = DEF_BYTE_W,
  parameter bit          REGISTERED = 1'b1,
  localparam int unsigned VEC_W     = LANES * BYTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] in_data,
  input  logic [VEC_W-1:0] in_ctrl,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_data
);

  logic [VEC_W-1:0] shuf_vec;
  logic [LANES-1:0] lane_zero_mask;

  bshuf_xbar #(
    .LANES (LANES),
    .BYTE_W(BYTE_W)
  ) xbar_i (
    .src_vec  (in_data),
    .ctrl_vec (in_ctrl),
    .shuf_vec (shuf_vec),
    .zero_mask(lane_zero_mask)
  );

  bshuf_stage #(
    .WIDTH     (VEC_W),
    .REGISTERED(REGISTERED)
  ) stage_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_valid(in_valid),
    .d_data (shuf_vec),
    .q_valid(out_valid),
    .q_data (out_data)
  );

endmodule

// File: rtl/bshuf_chk.sv
module bshuf_chk #(
  parameter int unsigned LANES      = 16,
  parameter int unsigned BYTE_W     = 8,
  parameter bit          REGISTERED = 1'b1,
  localparam int unsigned VEC_W     = LANES * BYTE_W,
  localparam int unsigned IDX_W     = $clog2(LANES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [VEC_W-1:0] in_data,
  input logic [VEC_W-1:0] in_ctrl,
  input logic             out_valid,
  input logic [VEC_W-1:0] out_data,
  input logic [LANES-1:0] zero_mask
);

  // Shift-based byte pick, a different form from the RTL's one-hot mux.
  function automatic logic [BYTE_W-1:0] pick(input logic [VEC_W-1:0] v,
                                             input logic [IDX_W-1:0] i);
    logic [VEC_W-1:0] sh;
    sh = v >> (BYTE_W * int'(i));
    return sh[BYTE_W-1:0];
  endfunction

  if (REGISTERED) begin : g_seq
    // R6
    a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    a_r6_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
    // R7
    a_r7_reset_clears: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && out_data == '0));
    // R8
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_data));

    for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
      // R2
      a_r2_zero_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && zero_mask[k]) |=> out_data[k*BYTE_W +: BYTE_W] == '0);
      // R3
      a_r3_copy_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ctrl[k*BYTE_W + BYTE_W - 1]) |=>
          out_data[k*BYTE_W +: BYTE_W] ==
            pick($past(in_data), $past(in_ctrl[k*BYTE_W +: IDX_W])));
    end
  end else begin : g_comb
    always_comb begin
      for (int k = 0; k < LANES; k++) begin
        if (in_valid && in_ctrl[k*BYTE_W + BYTE_W - 1]) begin
          a_r2_zero_comb: assert (out_data[k*BYTE_W +: BYTE_W] == '0);
        end
      end
    end
  end

endmodule

bind byte_shuffle_unit bshuf_chk #(
  .LANES     (LANES),
  .BYTE_W    (BYTE_W),
  .REGISTERED(REGISTERED)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_data  (in_data),
  .in_ctrl  (in_ctrl),
  .out_valid(out_valid),
  .out_data (out_data),
  .zero_mask(lane_zero_mask)
);

// File: tb/byte_shuffle_unit_tb_top.sv
`timescale 1ns/1ps
module byte_shuffle_unit_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] in_data = '0;
  logic [127:0] in_ctrl = '0;
  logic         out_valid;
  logic [127:0] out_data;

  always #2 clk = ~clk;

  byte_shuffle_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_data(in_data), .in_ctrl(in_ctrl),
    .out_valid(out_valid), .out_data(out_data)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [127:0] held = '0;

  // Behavioural model: byte arrays, integer indices.
  function automatic logic [127:0] model(input logic [127:0] d, input logic [127:0] c);
    byte unsigned src[16];
    byte unsigned res[16];
    logic [127:0] r;
    for (int b = 0; b < 16; b++) src[b] = d[8*b +: 8];
    for (int b = 0; b < 16; b++) begin
      int cb;
      cb = int'(c[8*b +: 8]);
      if (cb >= 128) res[b] = 8'h00;
      else res[b] = src[cb % 16];
    end
    for (int b = 0; b < 16; b++) r[8*b +: 8] = res[b];
    return r;
  endfunction

  function automatic logic [127:0] fill(input int f);
    logic [127:0] r;
    for (int b = 0; b < 16; b++) r[8*b +: 8] = 8'(f);
    return r;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge; the result is sampled at the next
  // falling edge, after the single register stage has updated.
  task automatic step(input string tag, input logic v, input logic [127:0] d, input logic [127:0] c);
    @(negedge clk);
    in_valid = v; in_data = d; in_ctrl = c;
    if (v) held = model(d, c);
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R6 valid"}, {127'b0, out_valid}, {127'b0, v});
    check(tag, out_data, held);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] ident, rev, d, c, base;
    for (int b = 0; b < 16; b++) begin
      ident[8*b +: 8] = 8'(b);
      rev[8*b +: 8]   = 8'(15 - b);
    end

    repeat (3) @(negedge clk);
    check("R7 reset valid", {127'b0, out_valid}, 128'd0);
    check("R7 reset data", out_data, 128'd0);
    rst_n = 1'b1;

    d = 128'h0f0e0d0c_0b0a0908_07060504_03020100 ^ 128'ha5a5a5a5_5a5a5a5a_c3c3c3c3_3c3c3c3c;
    step("R3 identity", 1'b1, d, ident);
    check("R3 identity equals input", out_data, d);
    step("R3 reversal", 1'b1, d, rev);
    step("R3 broadcast byte 5", 1'b1, d, fill(5));
    step("R3 all-zero control (byte 0 broadcast)", 1'b1, d, '0);
    step("R2 all lanes zero-forced", 1'b1, d, fill(8'h80));
    check("R2 zero result", out_data, 128'd0);
    step("R2 mixed zero lanes", 1'b1, d, ident | {8{16'h8000}});

    // R4: bits 6..4 set must match the same control with them clear.
    c = rev | fill(8'h70);
    step("R4 ignored bits", 1'b1, d, c);
    check("R4 ignored bits vs clean", out_data, model(d, rev));

    // R1: changing control byte 3 leaves other lanes alone.
    base = rnd128() & fill(8'h0f);
    step("R1 base", 1'b1, d, base);
    c = base; c[31:24] = 8'h8c;
    step("R1 one control byte changed", 1'b1, d, c);
    check("R1 other lanes unchanged",
          out_data & ~{96'd0, 8'hff, 24'd0}, model(d, base) & ~{96'd0, 8'hff, 24'd0});

    // R5: data and control are the same value.
    d = 128'h00_81_02_93_04_05_f6_07_08_09_0a_0b_0c_0d_0e_0f;
    step("R5 aliased operands", 1'b1, d, d);
    d = rev;
    step("R5 aliased reversal", 1'b1, d, d);

    // R8: idle input leaves the output unchanged.
    step("R8 hold with idle input", 1'b0, rnd128(), rnd128());
    step("R8 hold second idle", 1'b0, rnd128(), rnd128());

    for (int i = 0; i < 300; i++) begin
      d = rnd128();
      c = rnd128();
      if (i % 7 == 0) c = c & fill(8'h8f);
      step("R3 random", ($urandom % 4) != 0, d, c);
    end

    // R7: reset in the middle of a run.
    step("R7 preload", 1'b1, rnd128(), rev);
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b1; in_data = rnd128(); in_ctrl = ident;
    @(negedge clk);
    check("R7 mid-run valid cleared", {127'b0, out_valid}, 128'd0);
    check("R7 mid-run data cleared", out_data, 128'd0);
    rst_n = 1'b1; in_valid = 1'b0; held = '0;
    step("R6 after reset", 1'b1, d, ident);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule